// File: doc/BRIEF.md
# Oscillator Clock Failure Detector

This block watches a fast main oscillator clock against a slow reference clock that is assumed to run at all times. A small saturating counter in the main clock domain is forced to zero while the reference clock is low and counts main clock rising edges while it is high. When a high phase ends, the ref domain asks whether the count reached the configured minimum. A window that falls short is a failure, and a stalled main clock is one such case. The pass or fail result crosses into the reference domain through a flop synchroniser before any decision is made on it.

All control logic runs on the falling edge of the reference clock, which is the edge that closes each counting window. Detection is active only while both the detector enable and the oscillator enable are high. A failure does three things. It sets a latched event flag, which a read strobe clears. It drives an interrupt whenever that flag is set and the interrupt mask bit allows it. It sets a sticky fault output, which stays high until a separate clear strobe. A live status output shows the most recent synchronised result at any time.

Top module: `osc_fail_det`

## Requirements
- R1: While `rst` is sampled high on a falling reference edge, `evt_o`, `fault_o`, `irq_o` and `status_o` are all 0 after that edge.
- R2: When `det_en_i` or `osc_en_i` is 0 at a falling reference edge, that edge sets neither `evt_o` nor `fault_o`, and `status_o` is 0 while either input is 0.
- R3: A counting window is one high phase of `clk_ref`. The window passes if at least CNT_MIN (default 8) rising edges of `clk_main` occur in it, and fails otherwise. A stopped main clock therefore always fails.
- R4: The result of the window that ends at falling edge k is shown on `status_o` (1 = failure, gated by R2) from falling edge k+1. If detection is active at falling edge k+2, a failure at that point sets `evt_o` and `fault_o` after edge k+2.
- R5: Once set, `evt_o` stays 1 until a falling edge samples `rd_i` high. Such an edge clears it if no new failure is reported at the same edge.
- R6: If `rd_i` is high at the same falling edge that reports a new failure, `evt_o` stays 1.
- R7: `irq_o` is 1 exactly when `evt_o` is 1 and `irq_en_i` is 1.
- R8: Once set, `fault_o` stays 1 until a falling edge samples `fault_clr_i` high with no new failure reported at that edge. A new failure at that edge keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Slow reference clock; its high phase is the counting window, and its falling edge clocks the control logic |
| clk_main | input | 1 | Main oscillator clock being monitored |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of `clk_ref` |
| det_en_i | input | 1 | Detector enable |
| osc_en_i | input | 1 | Main oscillator enable; detection is forced off when 0 |
| irq_en_i | input | 1 | Interrupt mask bit for the event flag |
| rd_i | input | 1 | Status read strobe; clears the event flag |
| fault_clr_i | input | 1 | Clear strobe for the sticky fault output |
| evt_o | output | 1 | Latched failure event flag |
| status_o | output | 1 | Live failure status |
| irq_o | output | 1 | Masked interrupt request |
| fault_o | output | 1 | Sticky fault output |

## Verification
The bench builds the block with CNT_MIN = 8 and a two-stage synchroniser, and uses a reference high phase of 500 ns. It sweeps the main clock half period over 20, 31.25, 31.5 and 50 ns, plus a stopped clock. This gives windows of well above 8 edges, exactly 8 edges, a phase-dependent 7 or 8 edges, 5 edges, and none. Every one of these is crossed with all four enable combinations and with interleaved read, fault clear and mask changes. The bench counts the main edges in each high phase itself, so the exact 7/8 threshold is checked at its boundary.

// File: rtl/ocfd_pkg.sv
`timescale 1ns/100ps
package ocfd_pkg;

    localparam int unsigned CNT_MIN_DEF  = 8;
    localparam int unsigned SYNC_DEF     = 2;

    function automatic int unsigned cnt_width(input int unsigned lim);
        return $clog2(lim + 1);
    endfunction

    typedef struct packed {
        logic evt;
        logic fault;
    } ocfd_flags_t;

    typedef struct packed {
        logic active;
        logic fail_now;
    } ocfd_verdict_t;

endpackage

// File: rtl/ocfd_edge_counter.sv
`timescale 1ns/100ps
module ocfd_edge_counter #(
    parameter int unsigned CNT_MIN = ocfd_pkg::CNT_MIN_DEF
) (
    input  logic clk_main,
    input  logic ref_lvl,
    output logic reached
);
    localparam int unsigned   W   = ocfd_pkg::cnt_width(CNT_MIN);
    localparam logic [W-1:0]  LIM = W'(CNT_MIN);

    logic [W-1:0] cnt_q;

    // Held at zero while the reference is low; saturates so it never wraps.
    always_ff @(posedge clk_main or negedge ref_lvl) begin
        if (!ref_lvl)
            cnt_q <= '0;
        else if (cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q == LIM);
endmodule

// File: rtl/ocfd_sync.sv
`timescale 1ns/100ps
module ocfd_sync #(
    parameter int unsigned STAGES  = ocfd_pkg::SYNC_DEF,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(negedge clk_ref) begin
                if (rst) sh_q <= RST_VAL;
                else     sh_q <= d;
            end
        end else begin : g_chain
            always_ff @(negedge clk_ref) begin
                if (rst) sh_q <= {STAGES{RST_VAL}};
                else     sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ocfd_ctrl.sv
`timescale 1ns/100ps
module ocfd_ctrl
    import ocfd_pkg::*;
(
    input  logic        clk_ref,
    input  logic        rst,
    input  logic        det_en,
    input  logic        osc_en,
    input  logic        irq_en,
    input  logic        rd,
    input  logic        fclr,
    input  logic        win_ok,
    output ocfd_flags_t flags,
    output logic        status,
    output logic        irq
);
    ocfd_verdict_t vd;
    ocfd_flags_t   flags_q, flags_d;

    always_comb begin
        vd.active   = det_en & osc_en;
        vd.fail_now = vd.active & ~win_ok;
        // A fresh failure wins over either clear strobe.
        flags_d.evt   = vd.fail_now | (flags_q.evt   & ~rd);
        flags_d.fault = vd.fail_now | (flags_q.fault & ~fclr);
    end

    always_ff @(negedge clk_ref) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags  = flags_q;
    assign status = vd.fail_now;
    assign irq    = flags_q.evt & irq_en;
endmodule

// File: rtl/osc_fail_det.sv
`timescale 1ns/100ps
module osc_fail_det
    import ocfd_pkg::*;
#(
    parameter int unsigned CNT_MIN     = CNT_MIN_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic clk_ref,
    input  logic clk_main,
    input  logic rst,
    input  logic det_en_i,
    input  logic osc_en_i,
    input  logic irq_en_i,
    input  logic rd_i,
    input  logic fault_clr_i,
    output logic evt_o,
    output logic status_o,
    output logic irq_o,
    output logic fault_o
);
    logic        reached;
    logic        win_ok;
    ocfd_flags_t flags;

    ocfd_edge_counter #(.CNT_MIN(CNT_MIN)) u_cnt (
        .clk_main (clk_main),
        .ref_lvl  (clk_ref),
        .reached  (reached)
    );

    ocfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_ref (clk_ref),
        .rst     (rst),
        .d       (reached),
        .q       (win_ok)
    );

    ocfd_ctrl u_ctrl (
        .clk_ref (clk_ref),
        .rst     (rst),
        .det_en  (det_en_i),
        .osc_en  (osc_en_i),
        .irq_en  (irq_en_i),
        .rd      (rd_i),
        .fclr    (fault_clr_i),
        .win_ok  (win_ok),
        .flags   (flags),
        .status  (status_o),
        .irq     (irq_o)
    );

    assign evt_o   = flags.evt;
    assign fault_o = flags.fault;
endmodule

// File: rtl/ocfd_chk.sv
`timescale 1ns/100ps
module ocfd_chk (
    input logic clk_ref,
    input logic rst,
    input logic det_en_i,
    input logic osc_en_i,
    input logic irq_en_i,
    input logic rd_i,
    input logic fault_clr_i,
    input logic evt_o,
    input logic status_o,
    input logic irq_o,
    input logic fault_o
);
    // R5
    evt_hold_chk: assert property (@(negedge clk_ref) disable iff (rst)
        evt_o && !rd_i |=> evt_o);

    // R8
    fault_hold_chk: assert property (@(negedge clk_ref) disable iff (rst)
        fault_o && !fault_clr_i |=> fault_o);

    // R2
    idle_quiet_chk: assert property (@(negedge clk_ref) disable iff (rst)
        !evt_o && !(det_en_i && osc_en_i) |=> !evt_o);

    // R4
    status_to_evt_chk: assert property (@(negedge clk_ref) disable iff (rst)
        status_o |=> evt_o);

    // R4
    status_to_fault_chk: assert property (@(negedge clk_ref) disable iff (rst)
        status_o |=> fault_o);

    // R7
    irq_gate_chk: assert property (@(negedge clk_ref) disable iff (rst)
        irq_o |-> irq_en_i && evt_o);
endmodule

bind osc_fail_det ocfd_chk u_chk (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .det_en_i    (det_en_i),
    .osc_en_i    (osc_en_i),
    .irq_en_i    (irq_en_i),
    .rd_i        (rd_i),
    .fault_clr_i (fault_clr_i),
    .evt_o       (evt_o),
    .status_o    (status_o),
    .irq_o       (irq_o),
    .fault_o     (fault_o)
);

// File: tb/osc_fail_det_tb.sv
`timescale 1ns/100ps
module osc_fail_det_tb;
    localparam realtime REF_PERIOD = 1000.0;
    localparam int      CNT_MIN    = 8;
    localparam realtime WATCHDOG   = 400000.0;

    logic clk_ref = 1'b0, clk_main = 1'b0, rst = 1'b1;
    logic det_en = 1'b0, osc_en = 1'b0, irq_en = 1'b0, rd = 1'b0, fclr = 1'b0;
    logic evt_o, status_o, irq_o, fault_o;
    realtime mhalf = 20.0;

    int n_chk = 0, n_fail = 0, bcnt = 0;
    bit done = 0;
    logic m_evt = 0, m_fault = 0, m_s1 = 1, m_s2 = 1, m_rd_l = 0, m_fn_l = 0;

    osc_fail_det u_dut (
        .clk_ref(clk_ref), .clk_main(clk_main), .rst(rst),
        .det_en_i(det_en), .osc_en_i(osc_en), .irq_en_i(irq_en),
        .rd_i(rd), .fault_clr_i(fclr),
        .evt_o(evt_o), .status_o(status_o), .irq_o(irq_o), .fault_o(fault_o)
    );

    initial forever #(REF_PERIOD/2) clk_ref = ~clk_ref;

    // Main clock on a fractional phase so no edge meets a reference edge.
    initial begin
        #0.3;
        forever begin
            if (mhalf > 0.0) begin #(mhalf); clk_main = ~clk_main; end
            else #1.0;
        end
    end

    // R3: count main rising edges seen during each reference high phase.
    always @(posedge clk_main) if (clk_ref) bcnt++;

    // Expected state, derived from R3 to R8 at each closing edge.
    always @(negedge clk_ref) begin
        logic act, fn;
        if (rst) begin
            m_evt = 0; m_fault = 0; m_s1 = 1; m_s2 = 1; m_rd_l = 0; m_fn_l = 0;
        end else begin
            act     = det_en & osc_en;
            fn      = act & ~m_s2;
            m_evt   = fn | (m_evt & ~rd);
            m_fault = fn | (m_fault & ~fclr);
            m_rd_l  = rd;
            m_fn_l  = fn;
            m_s2    = m_s1;
            m_s1    = (bcnt >= CNT_MIN);
        end
        bcnt = 0;
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic d, input logic o, input logic ie,
                        input logic r, input logic fc, input realtime mh);
        @(posedge clk_ref); #1;
        chk((m_rd_l && m_fn_l) ? "R6 event kept on read with new failure"
                               : "R5 event flag", evt_o, m_evt);
        chk("R2 R3 R4 live status", status_o, det_en & osc_en & ~m_s2);
        chk("R7 masked interrupt", irq_o, m_evt & irq_en);
        chk("R8 sticky fault", fault_o, m_fault);
        det_en = d; osc_en = o; irq_en = ie; rd = r; fclr = fc; mhalf = mh;
    endtask

    initial begin
        realtime hv [5];
        hv[0] = 20.0; hv[1] = 31.25; hv[2] = 31.5; hv[3] = 50.0; hv[4] = 0.0;
        repeat (2) @(negedge clk_ref);
        @(posedge clk_ref); #1;
        chk("R1 event after reset", evt_o, 1'b0);
        chk("R1 fault after reset", fault_o, 1'b0);
        chk("R1 irq after reset", irq_o, 1'b0);
        chk("R1 status after reset", status_o, 1'b0);
        rst = 1'b0;
        for (int h = 0; h < 5; h++) begin
            for (int c = 0; c < 4; c++) begin
                for (int w = 0; w < 5; w++) begin
                    step(c[1], c[0], w[0] ^ c[0], w == 3, w == 2, hv[h]);
                end
            end
        end
        // Stopped clock, long fault, read while failing (R6), then recovery.
        for (int w = 0; w < 4; w++) step(1, 1, 1, w == 2, 1'b0, 0.0);
        for (int w = 0; w < 5; w++) step(1, 1, 1, 1'b1, 1'b1, 20.0);
        for (int w = 0; w < 3; w++) step(1, 1, 0, 1'b0, 1'b0, 20.0);
        step(0, 0, 0, 0, 0, 20.0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule